// File: doc/BRIEF.md
# ATA PIO Transfer Timing Engine

This block sits between a 16-bit memory-mapped register port and the parallel ATA cable. Software programs its timing words once for the chosen PIO speed. It then sets a device register address and, for a write, a transmit word. A write to the control register with the start bit set launches one single-word access. The engine drives the chip selects and the three-bit address. It produces a read or write strobe whose setup, active, hold and recovery phases each last a programmed number of clocks. Optionally it stretches the strobe while the device holds IORDY low. It captures read data into a receive register and raises a completion flag that can drive an interrupt line.

Task-file register accesses and data-port accesses use different active and recovery counts. The slow register timing and the fast data timing can therefore coexist without reprogramming between accesses. The data port is device address 0 with chip select 0.

Top module: `ata_pio_engine`

## Requirements
- R1: After reset every readable register returns 0, `irq` is low, both chip selects are high (`dev_cs_n` = 2'b11), both strobes are high and `dev_doe` is low.
- R2: Timing words are read/write at byte offsets 0x40, 0x44 and 0x48.
  - 0x40 is the task-file word: [15:8] recovery, [7:0] active.
  - 0x44 is the data-port word: [15:12] hold, [11:4] active, [3:0] setup.
  - 0x48 is the data-port recovery count in [7:0]; bits [15:8] read as 0.
  - Task-file accesses also take their setup and hold counts from 0x44.
- R3: Device address register 0x08 bits [2:0] drive `dev_addr`. Bit 3 set selects chip select 1 (`dev_cs_n` = 2'b01); bit 3 clear selects chip select 0 (`dev_cs_n` = 2'b10). Value 0 is the data port and uses data-port timing; every other value uses task-file timing.
- R4: Control register 0x00 has four bits: bit0 start (always reads 0), bit1 direction (1 = write), bit2 use-DMA, bit3 IORDY enable. An access runs in four phases, each lasting its programmed count, where a count of 0 means one clock:
  - setup: chip select and address valid;
  - active: strobe low;
  - hold: chip select, address and write data still valid;
  - recovery: chip select released.
- R5: For a write access, `dev_doe` is high and `dev_dout` carries the transmit register (0x0C) value from the first setup cycle through the last hold cycle.
- R6: For a read access, the receive register (0x10) captures `dev_din` on the clock edge that ends the active phase.
- R7: With IORDY enable set, the active phase does not end while `dev_iordy` is low. With it clear, `dev_iordy` has no effect.
- R8: Status register 0x04 bit0 reads 1 from the edge that accepts a start until recovery ends. A start written while busy launches nothing.
- R9: A control write with start and use-DMA both set launches no access.
- R10: Interrupt status 0x18 bit0 sets on the edge that ends recovery. Writing 1 clears it and writing 0 has no effect; a set on the same edge as a clear wins.
- R11: `irq` equals interrupt status bit0 AND interrupt mask (0x14) bit0.
- R12: Transfer length register 0x1C stores and returns a full 16-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| dev_cs_n | output | 2 | Chip selects, bit0 = CS0, bit1 = CS1, active low |
| dev_addr | output | 3 | Device register address |
| dev_rd_n | output | 1 | Read strobe, active low |
| dev_wr_n | output | 1 | Write strobe, active low |
| dev_dout | output | 16 | Write data toward the device |
| dev_doe | output | 1 | Data bus drive enable |
| dev_din | input | 16 | Read data from the device |
| dev_iordy | input | 1 | Device ready, low stretches the strobe |
| irq | output | 1 | Completion interrupt |

## Verification
Accesses are tried in several forms, and each pattern separates a different path:
- a data-port write against a task-file read, which tell the two timing sets and the two capture directions apart;
- a chip-select-1 read, which exposes the chip-select decode;
- all-zero timing words, which show the one-clock floor;
- IORDY held low with the enable set and again with it clear, which shows that stretching depends on the control bit alone.

A second start during an access, a start with use-DMA set, and write-0 against write-1 to the done flag probe the paths that must leave state untouched.

// File: rtl/ata_pio_engine.sv
module ata_pio_engine #(
  parameter int DW = 16,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic [1:0]    dev_cs_n,
  output logic [2:0]    dev_addr,
  output logic          dev_rd_n,
  output logic          dev_wr_n,
  output logic [DW-1:0] dev_dout,
  output logic          dev_doe,
  input  logic [DW-1:0] dev_din,
  input  logic          dev_iordy,
  output logic          irq
);
  localparam logic [AW-1:0] A_CTRL = AW'(7'h00);
  localparam logic [AW-1:0] A_STAT = AW'(7'h04);
  localparam logic [AW-1:0] A_DEV  = AW'(7'h08);
  localparam logic [AW-1:0] A_TX   = AW'(7'h0C);
  localparam logic [AW-1:0] A_RX   = AW'(7'h10);
  localparam logic [AW-1:0] A_MASK = AW'(7'h14);
  localparam logic [AW-1:0] A_ISTA = AW'(7'h18);
  localparam logic [AW-1:0] A_LEN  = AW'(7'h1C);
  localparam logic [AW-1:0] A_TTF  = AW'(7'h40);
  localparam logic [AW-1:0] A_TDP  = AW'(7'h44);
  localparam logic [AW-1:0] A_TREC = AW'(7'h48);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_ACT, S_HOLD, S_REC} phase_t;

  phase_t        state;
  logic [7:0]    cnt, lim;
  logic          ctl_dir, ctl_dma, ctl_ioen;
  logic [3:0]    devaddr;
  logic [DW-1:0] txbuf, rxbuf, imask, xlen, tf_tim, dp_tim;
  logic [7:0]    dp_rec;
  logic          done_q;
  logic [3:0]    a_addr;
  logic          a_wr, a_ioen;
  logic [DW-1:0] a_tx;
  logic [7:0]    n_setup, n_act, n_hold, n_rec;
  logic          busy, cnt_hit, advance, start_req, is_data, bus_on;

  function automatic logic [7:0] floor1(input logic [7:0] v);
    return (v == 8'd0) ? 8'd1 : v;
  endfunction

  assign busy      = (state != S_IDLE);
  assign start_req = reg_we && (reg_addr == A_CTRL) && reg_wdata[0] && !reg_wdata[2] && !busy;
  assign is_data   = (devaddr == 4'd0);

  always_comb begin
    case (state)
      S_SETUP: lim = n_setup;
      S_ACT:   lim = n_act;
      S_HOLD:  lim = n_hold;
      S_REC:   lim = n_rec;
      default: lim = 8'd1;
    endcase
  end

  assign cnt_hit = (cnt >= lim);
  assign advance = busy && cnt_hit && ((state != S_ACT) || !a_ioen || dev_iordy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= 8'd1;
      a_addr  <= 4'd0;
      a_wr    <= 1'b0;
      a_ioen  <= 1'b0;
      a_tx    <= '0;
      n_setup <= 8'd1;
      n_act   <= 8'd1;
      n_hold  <= 8'd1;
      n_rec   <= 8'd1;
    end else if (start_req) begin
      state   <= S_SETUP;
      cnt     <= 8'd1;
      a_addr  <= devaddr;
      a_wr    <= reg_wdata[1];
      a_ioen  <= reg_wdata[3];
      a_tx    <= txbuf;
      n_setup <= floor1({4'd0, dp_tim[3:0]});
      n_hold  <= floor1({4'd0, dp_tim[15:12]});
      n_act   <= is_data ? floor1(dp_tim[11:4]) : floor1(tf_tim[7:0]);
      n_rec   <= is_data ? floor1(dp_rec) : floor1(tf_tim[15:8]);
    end else if (busy) begin
      if (advance) begin
        cnt <= 8'd1;
        case (state)
          S_SETUP: state <= S_ACT;
          S_ACT:   state <= S_HOLD;
          S_HOLD:  state <= S_REC;
          default: state <= S_IDLE;
        endcase
      end else if (!cnt_hit) begin
        cnt <= cnt + 8'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_dir  <= 1'b0;
      ctl_dma  <= 1'b0;
      ctl_ioen <= 1'b0;
      devaddr  <= 4'd0;
      txbuf    <= '0;
      imask    <= '0;
      xlen     <= '0;
      tf_tim   <= '0;
      dp_tim   <= '0;
      dp_rec   <= 8'd0;
    end else if (reg_we) begin
      case (reg_addr)
        A_CTRL: begin
          ctl_dir  <= reg_wdata[1];
          ctl_dma  <= reg_wdata[2];
          ctl_ioen <= reg_wdata[3];
        end
        A_DEV:  devaddr <= reg_wdata[3:0];
        A_TX:   txbuf   <= reg_wdata;
        A_MASK: imask   <= reg_wdata;
        A_LEN:  xlen    <= reg_wdata;
        A_TTF:  tf_tim  <= reg_wdata;
        A_TDP:  dp_tim  <= reg_wdata;
        A_TREC: dp_rec  <= reg_wdata[7:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rxbuf <= '0;
    else if (advance && (state == S_ACT) && !a_wr)
      rxbuf <= dev_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      done_q <= 1'b0;
    else if (advance && (state == S_REC))
      done_q <= 1'b1;
    else if (reg_we && (reg_addr == A_ISTA) && reg_wdata[0])
      done_q <= 1'b0;
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {{(DW-4){1'b0}}, ctl_ioen, ctl_dma, ctl_dir, 1'b0};
      A_STAT:  reg_rdata = {{(DW-1){1'b0}}, busy};
      A_DEV:   reg_rdata = {{(DW-4){1'b0}}, devaddr};
      A_TX:    reg_rdata = txbuf;
      A_RX:    reg_rdata = rxbuf;
      A_MASK:  reg_rdata = imask;
      A_ISTA:  reg_rdata = {{(DW-1){1'b0}}, done_q};
      A_LEN:   reg_rdata = xlen;
      A_TTF:   reg_rdata = tf_tim;
      A_TDP:   reg_rdata = dp_tim;
      A_TREC:  reg_rdata = {{(DW-8){1'b0}}, dp_rec};
      default: reg_rdata = '0;
    endcase
  end

  assign bus_on   = (state == S_SETUP) || (state == S_ACT) || (state == S_HOLD);
  assign dev_cs_n = bus_on ? (a_addr[3] ? 2'b01 : 2'b10) : 2'b11;
  assign dev_addr = a_addr[2:0];
  assign dev_rd_n = !((state == S_ACT) && !a_wr);
  assign dev_wr_n = !((state == S_ACT) && a_wr);
  assign dev_doe  = bus_on && a_wr;
  assign dev_dout = a_tx;
  assign irq      = done_q && imask[0];
endmodule

module ata_pio_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_n,
  input logic       wr_n,
  input logic [1:0] cs_n,
  input logic       doe,
  input logic       iordy,
  input logic       ioen,
  input logic       busy,
  input logic       done,
  input logic       irq
);
  // R4
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n) !(!rd_n && !wr_n));
  // R3
  strobe_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> ($countones(cs_n) == 1));
  // R7
  iordy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!rd_n || !wr_n) && ioen && !iordy) |=> (!rd_n || !wr_n));
  // R8
  strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n || doe) |-> busy);
  // R10
  done_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R11
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n) irq |-> done);
endmodule

bind ata_pio_engine ata_pio_engine_chk chk_i (
  .clk(clk), .rst_n(rst_n), .rd_n(dev_rd_n), .wr_n(dev_wr_n), .cs_n(dev_cs_n),
  .doe(dev_doe), .iordy(dev_iordy), .ioen(a_ioen), .busy(busy), .done(done_q), .irq(irq)
);

// File: tb/ata_pio_engine_tb.sv
`timescale 1ns/1ps
module ata_pio_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [6:0]  reg_addr = 7'h00;
  logic [15:0] reg_wdata = 16'h0000;
  logic [15:0] reg_rdata;
  logic [1:0]  dev_cs_n;
  logic [2:0]  dev_addr;
  logic        dev_rd_n, dev_wr_n, dev_doe, irq;
  logic [15:0] dev_dout;
  logic [15:0] dev_din = 16'h0000;
  logic        dev_iordy = 1'b1;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  ata_pio_engine dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_cs_n(dev_cs_n),
    .dev_addr(dev_addr), .dev_rd_n(dev_rd_n), .dev_wr_n(dev_wr_n),
    .dev_dout(dev_dout), .dev_doe(dev_doe), .dev_din(dev_din),
    .dev_iordy(dev_iordy), .irq(irq)
  );

  // reference model state
  int m_dir, m_dma, m_ioen, m_done, q_wr, q_ioen;
  logic [3:0]  m_dev, q_addr;
  logic [15:0] m_tx, m_rx, m_mask, m_len, m_tf, m_dp, m_rec, q_tx;
  int ph[$];

  function automatic int fl1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic logic [15:0] m_read(input logic [6:0] a);
    case (a)
      7'h00: return 16'(m_ioen * 8 + m_dma * 4 + m_dir * 2);
      7'h04: return (ph.size() > 0) ? 16'h0001 : 16'h0000;
      7'h08: return {12'h000, m_dev};
      7'h0C: return m_tx;
      7'h10: return m_rx;
      7'h14: return m_mask;
      7'h18: return 16'(m_done);
      7'h1C: return m_len;
      7'h40: return m_tf;
      7'h44: return m_dp;
      7'h48: return {8'h00, m_rec[7:0]};
      default: return 16'h0000;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_dir = 0; m_dma = 0; m_ioen = 0; m_done = 0; q_wr = 0; q_ioen = 0;
      m_dev = 0; q_addr = 0; m_tx = 0; m_rx = 0; m_mask = 0; m_len = 0;
      m_tf = 0; m_dp = 0; m_rec = 0; q_tx = 0;
      ph.delete();
    end else begin
      automatic bit idle = (ph.size() == 0);
      automatic bit setdone = 0;
      if (!idle) begin
        if (!(ph[0] == 6 && q_ioen != 0 && !dev_iordy)) begin
          if (ph[0] == 6 && q_wr == 0) m_rx = dev_din;
          void'(ph.pop_front());
          if (ph.size() == 0) setdone = 1;
        end
      end
      if (reg_we) begin
        case (reg_addr)
          7'h00: begin
            m_dir = reg_wdata[1]; m_dma = reg_wdata[2]; m_ioen = reg_wdata[3];
            if (reg_wdata[0] && !reg_wdata[2] && idle) begin
              automatic bit dp = (m_dev == 0);
              automatic int ns = fl1(m_dp[3:0]);
              automatic int nh = fl1(m_dp[15:12]);
              automatic int na = dp ? fl1(m_dp[11:4]) : fl1(m_tf[7:0]);
              automatic int nr = dp ? fl1(m_rec[7:0]) : fl1(m_tf[15:8]);
              q_addr = m_dev; q_wr = m_dir; q_ioen = m_ioen; q_tx = m_tx;
              for (int i = 0; i < ns; i++) ph.push_back(1);
              for (int i = 0; i < na - 1; i++) ph.push_back(2);
              ph.push_back(6);
              for (int i = 0; i < nh; i++) ph.push_back(3);
              for (int i = 0; i < nr; i++) ph.push_back(4);
            end
          end
          7'h08: m_dev = reg_wdata[3:0];
          7'h0C: m_tx = reg_wdata;
          7'h14: m_mask = reg_wdata;
          7'h18: if (reg_wdata[0]) m_done = 0;
          7'h1C: m_len = reg_wdata;
          7'h40: m_tf = reg_wdata;
          7'h44: m_dp = reg_wdata;
          7'h48: m_rec = {8'h00, reg_wdata[7:0]};
          default: ;
        endcase
      end
      if (setdone) m_done = 1;
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      automatic int p = (ph.size() > 0) ? ph[0] : 0;
      automatic bit on = (p == 1 || p == 2 || p == 3 || p == 6);
      automatic bit act = (p == 2 || p == 6);
      automatic logic [1:0] ecs = on ? (q_addr[3] ? 2'b01 : 2'b10) : 2'b11;
      automatic logic [8:0] exp_p = {ecs, !(act && q_wr == 0), !(act && q_wr != 0),
                                     on && q_wr != 0, q_addr[2:0], (m_done != 0) && m_mask[0]};
      automatic logic [8:0] act_p = {dev_cs_n, dev_rd_n, dev_wr_n, dev_doe, dev_addr, irq};
      checks++;
      if (act_p !== exp_p) begin
        errors++;
        $display("FAIL R3/R4/R7/R11 pins t=%0t act=%h exp=%h", $time, act_p, exp_p);
      end
      checks++;
      if (reg_rdata !== m_read(reg_addr)) begin
        errors++;
        $display("FAIL R2/R6/R8/R10 rdata addr=%h act=%h exp=%h", reg_addr, reg_rdata, m_read(reg_addr));
      end
      if (on && q_wr != 0) begin
        checks++;
        if (dev_dout !== q_tx) begin
          errors++;
          $display("FAIL R5 dout act=%h exp=%h", dev_dout, q_tx);
        end
      end
    end
  end

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(input logic [6:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      reg_addr = 7'h04;
      #1;
      if (reg_rdata[0] == 1'b0) break;
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL R4 watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    for (int i = 0; i < 11; i++) begin
      automatic logic [6:0] a = (i < 8) ? 7'(i * 4) : 7'(8'h40 + (i - 8) * 4);
      rd_chk(a, 16'h0000, "R1 reset register");
    end
    chk("R1 reset pins", {13'd0, dev_cs_n, dev_doe}, 16'h0006);
    // R2 timing words
    wr(7'h44, 16'h2031); wr(7'h48, 16'hFF02); wr(7'h40, 16'h0405);
    rd_chk(7'h44, 16'h2031, "R2 data timing word");
    rd_chk(7'h48, 16'h0002, "R2 data recovery word");
    rd_chk(7'h40, 16'h0405, "R2 task-file timing word");
    // R12
    wr(7'h1C, 16'hBEEF);
    rd_chk(7'h1C, 16'hBEEF, "R12 transfer length");
    // data-port write, second start while busy ignored
    wr(7'h08, 16'h0000); wr(7'h0C, 16'hA55A);
    wr(7'h00, 16'h0003);
    chk("R5 write drive", {15'd0, dev_doe}, 16'h0001);
    wr(7'h00, 16'h0001);
    rd_chk(7'h04, 16'h0001, "R8 busy during access");
    wait_idle();
    rd_chk(7'h18, 16'h0001, "R10 done set");
    chk("R11 irq masked", {15'd0, irq}, 16'h0000);
    wr(7'h14, 16'h0001);
    #1 chk("R11 irq enabled", {15'd0, irq}, 16'h0001);
    wr(7'h18, 16'h0000);
    rd_chk(7'h18, 16'h0001, "R10 write zero keeps done");
    wr(7'h18, 16'h0001);
    rd_chk(7'h18, 16'h0000, "R10 write one clears done");
    // task-file read
    dev_din = 16'h0050;
    wr(7'h08, 16'h0007);
    wr(7'h00, 16'h0001);
    wait_idle();
    rd_chk(7'h10, 16'h0050, "R6 task-file read capture");
    // chip select 1 read
    dev_din = 16'h1234;
    wr(7'h08, 16'h000E);
    wr(7'h00, 16'h0001);
    #1 chk("R3 cs1 select", {14'd0, dev_cs_n}, 16'h0001);
    wait_idle();
    rd_chk(7'h10, 16'h1234, "R6 cs1 read capture");
    // zero counts
    wr(7'h44, 16'h0000); wr(7'h48, 16'h0000); wr(7'h40, 16'h0000);
    wr(7'h08, 16'h0000); wr(7'h0C, 16'h0F0F);
    wr(7'h00, 16'h0003);
    @(negedge clk); #1;
    chk("R4 zero setup is one clock", {15'd0, dev_wr_n}, 16'h0000);
    wait_idle();
    // IORDY stretch enabled
    wr(7'h44, 16'h0021); wr(7'h48, 16'h0001);
    dev_din = 16'hCAFE;
    dev_iordy = 1'b0;
    wr(7'h00, 16'h0009);
    repeat (8) @(negedge clk);
    #1 chk("R7 strobe stretched", {15'd0, dev_rd_n}, 16'h0000);
    dev_iordy = 1'b1;
    wait_idle();
    rd_chk(7'h10, 16'hCAFE, "R7 read after stretch");
    // IORDY ignored when disabled
    dev_din = 16'h1111;
    dev_iordy = 1'b0;
    wr(7'h00, 16'h0001);
    wait_idle();
    rd_chk(7'h04, 16'h0000, "R7 no stretch when disabled");
    rd_chk(7'h10, 16'h1111, "R7 read without stretch");
    dev_iordy = 1'b1;
    // use-DMA blocks PIO
    wr(7'h18, 16'h0001);
    wr(7'h00, 16'h0005);
    rd_chk(7'h04, 16'h0000, "R9 use-DMA no access");
    rd_chk(7'h18, 16'h0000, "R9 use-DMA no done");
    chk("R9 bus idle", {14'd0, dev_cs_n}, 16'h0003);
    repeat (4) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule